// File: doc/BRIEF.md
# Set/Clear Command Status Register

This block holds the control and status flags of a coprocessor. Software changes them by writing a command word in which every flag owns a clear request bit and a set request bit. It reads them back as a plain status word. Because each flag has its own request bits, one write can change any group of flags and leave the rest as they are, with no read-modify-write. A write that asserts both request bits of one flag is treated as a conflict and leaves that flag alone.

The flags are halt, broke, single-step, interrupt-on-break and a parameterised number of general-purpose signal flags (eight by default). Broke has only a clear request. The processor sets it by executing a break, through the `brk_evt` input. The interrupt request bits change no status bit. They drive the external `irq_req` line instead. The DMA busy input appears in the status word and is not stored here.

Halt is kept by a two-state machine:
- `HS_HALTED` is the reset state. It goes to `HS_RUNNING` on a write that requests only clear-halt.
- `HS_RUNNING` goes to `HS_HALTED` on a write that requests only set-halt. This transition, and no other, pulses `halt_evt` for one cycle.

Every other combination keeps the current state.

Top module: `scs_cmd_status`

## Requirements
- R1: Command bit layout: bit 0 clear-halt, bit 1 set-halt, bit 2 clear-broke, then clear/set pairs at bits 3/4 interrupt, 5/6 single-step, 7/8 interrupt-on-break, and 9+2k/10+2k for signal k (k = 0..7). For single-step, interrupt-on-break and each signal flag, a write with only the clear bit clears the flag and a write with only the set bit sets it. The change is visible in the cycle after the write.
- R2: A write that asserts both bits of one pair leaves that flag (or the interrupt line, or halt) unchanged.
- R3: Broke is set by a one-cycle `brk_evt` and cleared only by the clear-broke bit. When both arrive in the same cycle, broke ends set.
- R4: A set-halt-only write moves `HS_RUNNING` to `HS_HALTED` and pulses `halt_evt` high for exactly the one cycle in which halt first reads 1. A set-halt write while already halted produces no pulse.
- R5: A clear-halt-only write moves `HS_HALTED` to `HS_RUNNING`, and halt reads 0 from the next cycle.
- R6: The interrupt pair drives `irq_req` (set-only raises it, clear-only lowers it) and changes no status bit.
- R7: All flags named in one command word are updated in the same cycle.
- R8: Status layout: halt bit 0, broke bit 1, DMA busy bit 2 (follows `dma_busy` combinationally), bits 3 and 4 read 0, single-step bit 5, interrupt-on-break bit 6, signal k at bit 7+k.
- R9: After reset, status reads 0x0001 (halted only), `irq_req` is 0 and `halt_evt` is 0.
- R10: While `cmd_we` is low, `cmd_word` has no effect on any flag or output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_word | input | 9+2*NUM_SIG | Set/clear command word |
| brk_evt | input | 1 | Processor executed a break (sets broke) |
| dma_busy | input | 1 | DMA engine busy, shown in status |
| status_word | output | 7+NUM_SIG | Flag read-back word |
| irq_req | output | 1 | External interrupt request |
| halt_evt | output | 1 | One-cycle pulse on running-to-halted |

## Verification
Directed words try each pair with clear only, set only and both bits. This separates a correct conflict rule from one where set or clear simply wins. Set-halt is written both from running and from halted, so a pulse that depends on the edge can be told apart from one that depends on the level. Multi-flag words, writes with the strobe low and a break arriving together with clear-broke then check that updates happen together, that idle words are gated and that the hardware source wins. A long run of random words, strobes, breaks and DMA levels is then compared every cycle against a behavioural model.

// File: rtl/scs_pkg.sv
package scs_pkg;

    typedef enum logic {
        HS_RUNNING = 1'b0,
        HS_HALTED  = 1'b1
    } halt_state_e;

    // command word positions (the pair order is decoded by the flag bank)
    localparam int CMD_CLR_HALT  = 0;
    localparam int CMD_SET_HALT  = 1;
    localparam int CMD_CLR_BROKE = 2;
    localparam int CMD_PAIR_BASE = 3;

    // pair indices inside the flag bank
    localparam int PAIR_IRQ   = 0;
    localparam int PAIR_SSTEP = 1;
    localparam int PAIR_IBRK  = 2;
    localparam int PAIR_SIG0  = 3;

    // status word positions
    localparam int ST_HALT     = 0;
    localparam int ST_BROKE    = 1;
    localparam int ST_DMA      = 2;
    localparam int ST_SSTEP    = 5;
    localparam int ST_IBRK     = 6;
    localparam int ST_SIG_BASE = 7;

endpackage

// File: rtl/scs_pair_resolve.sv
module scs_pair_resolve #(
    parameter int N = 11
) (
    input  logic           we,
    input  logic [2*N-1:0] pair_cmd,
    input  logic [N-1:0]   cur,
    output logic [N-1:0]   nxt
);
    // pair i: clear request at 2*i, set request at 2*i+1
    for (genvar i = 0; i < N; i++) begin : g_pair
        logic clr_b;
        logic set_b;
        assign clr_b  = pair_cmd[2*i];
        assign set_b  = pair_cmd[2*i+1];
        // exactly one request of the pair acts; both or none keep the value
        assign nxt[i] = (we && (clr_b ^ set_b)) ? set_b : cur[i];
    end
endmodule

// File: rtl/scs_flag_bank.sv
module scs_flag_bank #(
    parameter int N = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [2*N-1:0] pair_cmd,
    output logic [N-1:0]   flags
);
    logic [N-1:0] flags_d;

    scs_pair_resolve #(.N(N)) u_resolve (
        .we       (we),
        .pair_cmd (pair_cmd),
        .cur      (flags),
        .nxt      (flags_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= flags_d;
    end
endmodule

// File: rtl/scs_broke_reg.sv
module scs_broke_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic clr_req,
    input  logic brk_evt,
    output logic broke
);
    // hardware break outranks a software clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              broke <= 1'b0;
        else if (brk_evt)        broke <= 1'b1;
        else if (we && clr_req)  broke <= 1'b0;
    end
endmodule

// File: rtl/scs_halt_fsm.sv
module scs_halt_fsm
    import scs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic clr_req,
    input  logic set_req,
    output logic halted,
    output logic halt_evt
);
    halt_state_e state_q;
    halt_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_RUNNING: if (we && set_req && !clr_req) state_d = HS_HALTED;
            HS_HALTED:  if (we && clr_req && !set_req) state_d = HS_RUNNING;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HS_HALTED;
        else        state_q <= state_d;
    end

    // outputs: event is registered so it aligns with the halt status bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) halt_evt <= 1'b0;
        else        halt_evt <= (state_q == HS_RUNNING) && (state_d == HS_HALTED);
    end

    assign halted = (state_q == HS_HALTED);
endmodule

// File: rtl/scs_cmd_status.sv
module scs_cmd_status
    import scs_pkg::*;
#(
    parameter  int NUM_SIG  = 8,
    localparam int NUM_PAIR = NUM_SIG + 3,
    localparam int CMD_W    = CMD_PAIR_BASE + 2 * NUM_PAIR,
    localparam int STAT_W   = ST_SIG_BASE + NUM_SIG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              brk_evt,
    input  logic              dma_busy,
    output logic [STAT_W-1:0] status_word,
    output logic              irq_req,
    output logic              halt_evt
);
    logic                halted;
    logic                broke;
    logic [NUM_PAIR-1:0] pair_flags;

    scs_halt_fsm u_halt (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cmd_we),
        .clr_req  (cmd_word[CMD_CLR_HALT]),
        .set_req  (cmd_word[CMD_SET_HALT]),
        .halted   (halted),
        .halt_evt (halt_evt)
    );

    scs_broke_reg u_broke (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cmd_we),
        .clr_req (cmd_word[CMD_CLR_BROKE]),
        .brk_evt (brk_evt),
        .broke   (broke)
    );

    scs_flag_bank #(.N(NUM_PAIR)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cmd_we),
        .pair_cmd (cmd_word[CMD_PAIR_BASE +: 2*NUM_PAIR]),
        .flags    (pair_flags)
    );

    assign irq_req = pair_flags[PAIR_IRQ];

    always_comb begin
        status_word                          = '0;
        status_word[ST_HALT]                 = halted;
        status_word[ST_BROKE]                = broke;
        status_word[ST_DMA]                  = dma_busy;
        status_word[ST_SSTEP]                = pair_flags[PAIR_SSTEP];
        status_word[ST_IBRK]                 = pair_flags[PAIR_IBRK];
        status_word[ST_SIG_BASE +: NUM_SIG]  = pair_flags[PAIR_SIG0 +: NUM_SIG];
    end
endmodule

// File: rtl/scs_cmd_status_chk.sv
module scs_cmd_status_chk #(
    parameter  int NUM_SIG = 8,
    localparam int CMD_W   = 9 + 2 * NUM_SIG,
    localparam int STAT_W  = 7 + NUM_SIG
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_we,
    input logic [CMD_W-1:0]  cmd_word,
    input logic              brk_evt,
    input logic [STAT_W-1:0] status_word,
    input logic              irq_req,
    input logic              halt_evt
);
    a_r2_halt_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we && cmd_word[0] && cmd_word[1] |=> $stable(status_word[0]));

    a_r4_evt_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        halt_evt |-> status_word[0] && !$past(status_word[0]));

    a_r4_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
        halt_evt |=> !halt_evt);

    a_r5_resume: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we && cmd_word[0] && !cmd_word[1] |=> !status_word[0]);

    a_r6_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we && cmd_word[4] && !cmd_word[3] |=> irq_req);

    a_r3_broke_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_word[1]) |-> $past(brk_evt));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_we && !brk_evt |=> $stable(status_word[STAT_W-1:3])
                               && $stable(status_word[1:0]) && $stable(irq_req));
endmodule

bind scs_cmd_status scs_cmd_status_chk #(.NUM_SIG(NUM_SIG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_we      (cmd_we),
    .cmd_word    (cmd_word),
    .brk_evt     (brk_evt),
    .status_word (status_word),
    .irq_req     (irq_req),
    .halt_evt    (halt_evt)
);

// File: tb/scs_cmd_status_test.sv
module scs_cmd_status_test;
    localparam int NS = 8;
    localparam int CW = 9 + 2 * NS;
    localparam int SW = 7 + NS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_we = 1'b0;
    logic [CW-1:0] cmd_word = '0;
    logic          brk_evt = 1'b0;
    logic          dma_busy = 1'b0;
    logic [SW-1:0] status_word;
    logic          irq_req;
    logic          halt_evt;

    int total = 0;
    int bad = 0;
    bit done = 0;

    scs_cmd_status #(.NUM_SIG(NS)) uut (
        .clk (clk), .rst_n (rst_n), .cmd_we (cmd_we), .cmd_word (cmd_word),
        .brk_evt (brk_evt), .dma_busy (dma_busy), .status_word (status_word),
        .irq_req (irq_req), .halt_evt (halt_evt)
    );

    always #5 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    bit m_halt, m_broke, m_irq, m_evt, m_ss, m_ib;
    bit [NS-1:0] m_sig;

    function automatic bit apply_pair(bit cur, bit clr, bit st);
        if (clr && !st) return 1'b0;
        if (st && !clr) return 1'b1;
        return cur;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_halt = 1; m_broke = 0; m_irq = 0; m_evt = 0; m_ss = 0; m_ib = 0; m_sig = '0;
        end else begin
            m_evt = 0;
            if (cmd_we) begin
                if (cmd_word[1] && !cmd_word[0] && !m_halt) begin m_halt = 1; m_evt = 1; end
                else if (cmd_word[0] && !cmd_word[1]) m_halt = 0;
                if (cmd_word[2]) m_broke = 0;
                m_irq = apply_pair(m_irq, cmd_word[3], cmd_word[4]);
                m_ss  = apply_pair(m_ss,  cmd_word[5], cmd_word[6]);
                m_ib  = apply_pair(m_ib,  cmd_word[7], cmd_word[8]);
                for (int k = 0; k < NS; k++)
                    m_sig[k] = apply_pair(m_sig[k], cmd_word[9+2*k], cmd_word[10+2*k]);
            end
            if (brk_evt) m_broke = 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R4 R5 halt bit", 32'(status_word[0]), 32'(m_halt));
            check("R3 broke bit", 32'(status_word[1]), 32'(m_broke));
            check("R8 dma/reserved bits", 32'(status_word[4:2]), {29'd0, 2'b00, dma_busy});
            check("R1 R2 single-step", 32'(status_word[5]), 32'(m_ss));
            check("R1 R2 intr-on-break", 32'(status_word[6]), 32'(m_ib));
            check("R1 R2 R7 signals", 32'(status_word[SW-1:7]), 32'(m_sig));
            check("R6 irq_req", 32'(irq_req), 32'(m_irq));
            check("R4 halt_evt", 32'(halt_evt), 32'(m_evt));
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [CW-1:0] pbit(int pair, bit st);
        return CW'(1) << (3 + 2 * pair + (st ? 1 : 0));
    endfunction

    task automatic cmd(input logic [CW-1:0] w);
        @(negedge clk); #2;
        cmd_we = 1; cmd_word = w;
        @(negedge clk); #2;
        cmd_we = 0; cmd_word = '0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        // R9: reset state
        check("R9 reset status", 32'(status_word), 32'h0001);
        check("R9 reset irq", 32'(irq_req), 0);
        check("R9 reset evt", 32'(halt_evt), 0);

        cmd(CW'(1));                                  // clear-halt only
        check("R5 resume", 32'(status_word[0]), 0);

        cmd(CW'(2));                                  // set-halt from running
        check("R4 halt evt pulse", 32'(halt_evt), 1);
        check("R4 halt set", 32'(status_word[0]), 1);
        @(negedge clk);
        check("R4 evt one cycle", 32'(halt_evt), 0);
        cmd(CW'(2));                                  // set-halt while halted
        check("R4 no evt when halted", 32'(halt_evt), 0);

        cmd(CW'(3));                                  // both halt bits
        check("R2 halt conflict", 32'(status_word[0]), 1);

        // R7: several flags in one word
        cmd(CW'(1) | pbit(1, 1) | pbit(3 + 3, 1) | pbit(0, 1));
        check("R7 multi-flag status", 32'(status_word), 32'h0420);
        check("R7 multi-flag irq", 32'(irq_req), 1);

        cmd(pbit(0, 0) | pbit(0, 1));                 // irq conflict
        check("R6 R2 irq conflict", 32'(irq_req), 1);
        cmd(pbit(0, 0));
        check("R6 irq clear", 32'(irq_req), 0);
        check("R6 status untouched", 32'(status_word), 32'h0420);

        // R10: word present without strobe
        @(negedge clk); #2 cmd_word = pbit(3, 1) | CW'(2); cmd_we = 0;
        @(negedge clk);
        check("R10 ignored word", 32'(status_word), 32'h0420);
        #2 cmd_word = '0;

        // R3: broke
        @(negedge clk); #2 brk_evt = 1;
        @(negedge clk); #2 brk_evt = 0;
        check("R3 break sets", 32'(status_word[1]), 1);
        cmd(CW'(4));
        check("R3 clear broke", 32'(status_word[1]), 0);
        @(negedge clk); #2 brk_evt = 1; cmd_we = 1; cmd_word = CW'(4);
        @(negedge clk); #2 brk_evt = 0; cmd_we = 0; cmd_word = '0;
        check("R3 break wins", 32'(status_word[1]), 1);

        // R8: dma mirror and reserved bits
        @(negedge clk); #2 dma_busy = 1;
        @(negedge clk);
        check("R8 dma bit", 32'(status_word[2]), 1);
        check("R8 reserved", 32'(status_word[4:3]), 0);
        #2 dma_busy = 0;

        // R1: all signals set, then sig7 cleared, intr-on-break set
        begin
            logic [CW-1:0] w = '0;
            for (int k = 0; k < NS; k++) w |= pbit(3 + k, 1);
            cmd(w);
        end
        cmd(pbit(3 + 7, 0) | pbit(2, 1) | pbit(1, 0));
        check("R1 signals", 32'(status_word[SW-1:7]), 32'h7F);
        check("R1 intr-on-break", 32'(status_word[6]), 1);
        check("R1 single-step cleared", 32'(status_word[5]), 0);

        // random phase, checked by the model every cycle
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk); #2;
            cmd_we   = ($urandom_range(0, 3) != 0);
            cmd_word = CW'({$urandom, $urandom});
            brk_evt  = ($urandom_range(0, 7) == 0);
            dma_busy = $urandom_range(0, 1) == 1;
        end
        @(negedge clk); #2 cmd_we = 0; brk_evt = 0;
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule